// File: doc/BRIEF.md
# Programmable Loop Divider and Phase Comparator

This block is the digital core of a frequency synthesizer loop. It takes one of two oscillator pulse streams, divides it by a programmed ratio, and compares the divided stream against a reference pulse stream. The comparison drives a three-state pump output. The output sources high when the divided signal runs ahead, sinks low when the reference runs ahead, and is released (output enable low) when neither side is pending. Everything runs in one clock domain. Every oscillator or reference event arrives as a one-cycle strobe, and each strobe stands for one cycle of that signal.

Two control inputs pick the path and the division structure. With `sel_fm` low, the low-band strobe is divided. `swallow_en` then chooses between a two-modulus swallow divider (ratio 256 to 65536) and a direct 12-bit counter (ratio 4 to 4096). With `sel_fm` high, the high-band strobe first passes through a fixed halving stage and then enters the swallow divider, so the overall division is twice the programmed ratio. The ratio and the two selects are held in a shadow register. That register reloads only at a divider terminal count, so a change never cuts a divider cycle short.

Top module: `pll_synth_core`

## Requirements
- R1: With `sel_fm`=0 and `swallow_en`=0, `div_out` pulses once every N counted `am_pulse` strobes. N is `ratio[11:0]`, and `ratio[15:12]` and `fm_pulse` have no effect.
- R2: In direct mode, `ratio[11:0]`=0 divides by 4096.
- R3: In direct mode, a nonzero `ratio[11:0]` below 4 divides by 4.
- R4: With `sel_fm`=0 and `swallow_en`=1, `div_out` pulses once every N `am_pulse` strobes, where N is the full 16-bit `ratio`. A ratio of 0 divides by 65536. The count is formed as 16·P + A, with A = `ratio[3:0]` and P = `ratio[15:4]`.
- R5: In swallow mode, a nonzero ratio below 256 divides by 256.
- R6: With `sel_fm`=1, `div_out` pulses once every 2·N `fm_pulse` strobes, using the swallow ratio rules whatever `swallow_en` is, and `am_pulse` has no effect.
- R7: A change of `ratio`, `sel_fm` or `swallow_en` takes effect only at the next `div_out` pulse. The divider period in progress completes with the old setting.
- R8: A divider pulse that arrives while no reference is pending makes the pump drive high (`pump_oe`=1, `pump_level`=1). The pump holds this state until a reference pulse arrives.
- R9: A reference pulse that arrives while no divider pulse is pending makes the pump drive low (`pump_oe`=1, `pump_level`=0).
- R10: Once both a divider pulse and a reference pulse are pending, the pump floats (`pump_oe`=0) and both pending flags clear on the next cycle.
- R11: During and right after reset, `div_out`=0 and `pump_oe`=0.
- R12: Only strobed cycles are counted. A gapped `am_pulse` stream at half rate doubles the `div_out` period in clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset; loads the shadow setting from the inputs |
| am_pulse | input | 1 | Low-band oscillator strobe, one per oscillator cycle |
| fm_pulse | input | 1 | High-band oscillator strobe, one per oscillator cycle |
| ref_pulse | input | 1 | Reference strobe, one per reference cycle |
| sel_fm | input | 1 | 1 selects the high-band path through the halving stage |
| swallow_en | input | 1 | On the low-band path, 1 selects the swallow divider, 0 the direct counter |
| ratio | input | 16 | Programmed division ratio |
| div_out | output | 1 | One-cycle pulse at each divider terminal count |
| pump_oe | output | 1 | Pump output enable; 0 means high impedance |
| pump_level | output | 1 | Pump drive level while enabled: 1 high, 0 low |

## Verification
The hardest condition to reach from the ports is a setting change that lands in the middle of a divider period. The old and new ratios must then both be visible, one in each of two consecutive periods. The bench first locks onto a terminal count. It then changes the ratio partway through the next period and measures two back-to-back intervals. The 65536 encoding of a zero swallow ratio is also costly to reach, so it is measured once, at the end, over a single full period. Both comparator orderings are produced by holding the oscillator strobe off and pulsing the reference and the divider by hand.

// File: rtl/pll_synth_pkg.sv
package pll_synth_pkg;

    localparam int RATIO_W     = 16;
    localparam int SWALLOW_W   = 4;
    localparam int MAIN_W      = RATIO_W - SWALLOW_W;
    localparam int DIRECT_W    = 12;
    localparam int MOD_LOW     = 1 << SWALLOW_W;
    localparam int MOD_W       = SWALLOW_W + 1;
    localparam int MAIN_CNT_W  = MAIN_W + 1;
    localparam int SWALLOW_MIN = 256;
    localparam int DIRECT_MIN  = 4;

    typedef enum logic {SRC_AM = 1'b0, SRC_FM = 1'b1} src_e;
    typedef enum logic {MODE_DIRECT = 1'b0, MODE_SWALLOW = 1'b1} div_mode_e;

    typedef struct packed {
        src_e               src;
        div_mode_e          mode;
        logic [RATIO_W-1:0] ratio;
    } div_cfg_t;

    // Build the effective divider setting, applying the per-mode floor.
    function automatic div_cfg_t make_cfg(input logic sel_fm,
                                          input logic swallow_en,
                                          input logic [RATIO_W-1:0] raw);
        div_cfg_t c;
        c.src  = sel_fm ? SRC_FM : SRC_AM;
        c.mode = (sel_fm || swallow_en) ? MODE_SWALLOW : MODE_DIRECT;
        if (c.mode == MODE_SWALLOW) begin
            c.ratio = raw;
            if (raw != '0 && raw < RATIO_W'(SWALLOW_MIN))
                c.ratio = RATIO_W'(SWALLOW_MIN);
        end else begin
            c.ratio = '0;
            c.ratio[DIRECT_W-1:0] = raw[DIRECT_W-1:0];
            if (raw[DIRECT_W-1:0] != '0 && raw[DIRECT_W-1:0] < DIRECT_W'(DIRECT_MIN))
                c.ratio[DIRECT_W-1:0] = DIRECT_W'(DIRECT_MIN);
        end
        return c;
    endfunction

endpackage

// File: rtl/div2_prescaler.sv
module div2_prescaler (
    input  logic clk,
    input  logic rst,
    input  logic in_pulse,
    output logic out_pulse
);
    logic phase_q;

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= 1'b0;
        else if (in_pulse)
            phase_q <= ~phase_q;
    end

    assign out_pulse = in_pulse & phase_q;

    // R6: the halved stream never yields two strobes in a row
    assert_halved_spacing_R6: assert property (@(posedge clk) disable iff (rst)
        out_pulse |=> !out_pulse);

endmodule

// File: rtl/ratio_divider.sv
module ratio_divider
    import pll_synth_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cnt_en,
    input  div_cfg_t cfg_in,
    output div_cfg_t cfg_q,
    output logic     div_tc
);
    logic [DIRECT_W-1:0]   dcnt;
    logic [MOD_W-1:0]      mcnt;
    logic [SWALLOW_W-1:0]  a_left;
    logic [MAIN_CNT_W-1:0] p_left;

    // Reload values taken from the pending setting
    logic [DIRECT_W-1:0]   ld_dcnt;
    logic [SWALLOW_W-1:0]  ld_a;
    logic [MAIN_CNT_W-1:0] ld_p;

    always_comb begin
        ld_dcnt = cfg_in.ratio[DIRECT_W-1:0] - DIRECT_W'(1);
        ld_a    = cfg_in.ratio[SWALLOW_W-1:0];
        if (cfg_in.ratio[RATIO_W-1:SWALLOW_W] == '0)
            ld_p = MAIN_CNT_W'(1 << MAIN_W);
        else
            ld_p = {1'b0, cfg_in.ratio[RATIO_W-1:SWALLOW_W]};
    end

    // Dual-modulus stage: /17 while swallow count remains, /16 after
    logic             a_active;
    logic [MOD_W-1:0] mod_last;
    logic             mod_end;
    logic             wrap;

    always_comb begin
        a_active = (a_left != '0);
        mod_last = a_active ? MOD_W'(MOD_LOW) : MOD_W'(MOD_LOW - 1);
        mod_end  = (mcnt == mod_last);
        if (cfg_q.mode == MODE_SWALLOW)
            wrap = cnt_en && mod_end && (p_left == MAIN_CNT_W'(1));
        else
            wrap = cnt_en && (dcnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst || wrap) begin
            cfg_q  <= cfg_in;
            dcnt   <= ld_dcnt;
            mcnt   <= '0;
            a_left <= ld_a;
            p_left <= ld_p;
        end else if (cnt_en) begin
            if (cfg_q.mode == MODE_SWALLOW) begin
                if (mod_end) begin
                    mcnt   <= '0;
                    p_left <= p_left - MAIN_CNT_W'(1);
                    if (a_active)
                        a_left <= a_left - SWALLOW_W'(1);
                end else begin
                    mcnt <= mcnt + MOD_W'(1);
                end
            end else begin
                dcnt <= dcnt - DIRECT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            div_tc <= 1'b0;
        else
            div_tc <= wrap;
    end

    // R12: a terminal count only follows a counted strobe
    assert_tc_needs_strobe_R12: assert property (@(posedge clk) disable iff (rst)
        div_tc |-> $past(cnt_en));

    // R12: counters hold while no strobe arrives
    assert_hold_idle_R12: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> ($stable(dcnt) && $stable(mcnt) && $stable(p_left)));

    // R4: modulus stage never exceeds the /17 range
    assert_modulus_range_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == MODE_SWALLOW) |-> (mcnt <= MOD_W'(MOD_LOW)));

    // R7: the active setting only changes at a terminal count
    assert_setting_held_R7: assert property (@(posedge clk) disable iff (rst)
        !div_tc |-> $stable(cfg_q));

endmodule

// File: rtl/phase_detector.sv
module phase_detector (
    input  logic clk,
    input  logic rst,
    input  logic div_edge,
    input  logic ref_edge,
    output logic pump_oe,
    output logic pump_level
);
    logic up_q;
    logic dn_q;
    logic both;

    assign both = up_q & dn_q;

    always_ff @(posedge clk) begin
        if (rst || both) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else begin
            up_q <= up_q | div_edge;
            dn_q <= dn_q | ref_edge;
        end
    end

    assign pump_oe    = up_q ^ dn_q;
    assign pump_level = up_q & ~dn_q;

    // R10: coincident flags clear on the following cycle
    assert_flags_clear_R10: assert property (@(posedge clk) disable iff (rst)
        both |=> (!up_q && !dn_q));

    // R8: a divider edge with nothing pending raises the up flag
    assert_up_on_divider_R8: assert property (@(posedge clk) disable iff (rst)
        (div_edge && !up_q && !dn_q) |=> up_q);

    // R9: a reference edge with nothing pending raises the down flag
    assert_down_on_reference_R9: assert property (@(posedge clk) disable iff (rst)
        (ref_edge && !up_q && !dn_q) |=> dn_q);

endmodule

// File: rtl/pll_synth_core.sv
module pll_synth_core
    import pll_synth_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               am_pulse,
    input  logic               fm_pulse,
    input  logic               ref_pulse,
    input  logic               sel_fm,
    input  logic               swallow_en,
    input  logic [RATIO_W-1:0] ratio,
    output logic               div_out,
    output logic               pump_oe,
    output logic               pump_level
);
    div_cfg_t cfg_in;
    div_cfg_t cfg_q;
    logic     fm_half;
    logic     cnt_en;

    always_comb cfg_in = make_cfg(sel_fm, swallow_en, ratio);

    div2_prescaler u_prescale (
        .clk       (clk),
        .rst       (rst),
        .in_pulse  (fm_pulse),
        .out_pulse (fm_half)
    );

    assign cnt_en = (cfg_q.src == SRC_FM) ? fm_half : am_pulse;

    ratio_divider u_divider (
        .clk    (clk),
        .rst    (rst),
        .cnt_en (cnt_en),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q),
        .div_tc (div_out)
    );

    phase_detector u_compare (
        .clk        (clk),
        .rst        (rst),
        .div_edge   (div_out),
        .ref_edge   (ref_pulse),
        .pump_oe    (pump_oe),
        .pump_level (pump_level)
    );

    // R11: nothing is driven in the cycle after reset
    assert_quiet_after_reset_R11: assert property (@(posedge clk)
        $past(rst) |-> (!div_out && !pump_oe));

endmodule

// File: tb/pll_synth_core_test.sv
module pll_synth_core_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        am_level = 1'b0;
    logic        am_alt = 1'b0;
    logic        alt_tog = 1'b0;
    logic        fm_pulse = 1'b0;
    logic        ref_pulse = 1'b0;
    logic        sel_fm = 1'b0;
    logic        swallow_en = 1'b0;
    logic [15:0] ratio = 16'd4;
    wire         am_pulse = am_alt ? alt_tog : am_level;
    logic        div_out;
    logic        pump_oe;
    logic        pump_level;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    initial forever begin
        @(negedge clk);
        alt_tog = ~alt_tog;
    end

    pll_synth_core uut (
        .clk        (clk),
        .rst        (rst),
        .am_pulse   (am_pulse),
        .fm_pulse   (fm_pulse),
        .ref_pulse  (ref_pulse),
        .sel_fm     (sel_fm),
        .swallow_en (swallow_en),
        .ratio      (ratio),
        .div_out    (div_out),
        .pump_oe    (pump_oe),
        .pump_level (pump_level)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_tc();
        do @(negedge clk); while (!div_out);
    endtask

    task automatic next_period(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!div_out);
    endtask

    // Apply a setting, let it load at a terminal count, measure one period
    task automatic measure(input string tag, input logic fm, input logic sw,
                           input logic [15:0] r, input int exp);
        int n;
        sel_fm = fm;
        swallow_en = sw;
        ratio = r;
        wait_tc();
        next_period(n);
        check(tag, n, exp);
    endtask

    task automatic pulse_am(input int n);
        @(negedge clk);
        am_level = 1'b1;
        repeat (n) @(negedge clk);
        am_level = 1'b0;
    endtask

    task automatic test_reset();
        ratio = 16'd4; sel_fm = 1'b0; swallow_en = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R11 div_out in reset", int'(div_out), 0);
        check("R11 pump_oe in reset", int'(pump_oe), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R11 pump_oe after reset", int'(pump_oe), 0);
    endtask

    task automatic test_compare();
        @(negedge clk);
        ref_pulse = 1'b1;
        @(negedge clk);
        ref_pulse = 1'b0;
        check("R9 pump_oe ref first", int'(pump_oe), 1);
        check("R9 pump_level ref first", int'(pump_level), 0);
        repeat (3) @(negedge clk);
        check("R9 pump_level held low", int'(pump_level), 0);
        pulse_am(4);
        check("R1 div_out after 4 strobes", int'(div_out), 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R10 pump floats after both", int'(pump_oe), 0);
        end
        pulse_am(4);
        repeat (3) @(negedge clk);
        check("R8 pump_oe divider first", int'(pump_oe), 1);
        check("R8 pump_level divider first", int'(pump_level), 1);
        repeat (5) @(negedge clk);
        check("R8 pump high held", int'(pump_oe & pump_level), 1);
    endtask

    task automatic test_direct();
        am_level = 1'b1;
        fm_pulse = 1'b1;
        measure("R1 direct 200, upper bits set", 1'b0, 1'b0, 16'hF0C8, 200);
        measure("R1 direct 37", 1'b0, 1'b0, 16'd37, 37);
        measure("R2 direct zero is 4096", 1'b0, 1'b0, 16'h1000, 4096);
        measure("R3 direct 1 floors to 4", 1'b0, 1'b0, 16'd1, 4);
        measure("R3 direct 3 floors to 4", 1'b0, 1'b0, 16'd3, 4);
    endtask

    task automatic test_swallow();
        measure("R4 swallow 1000", 1'b0, 1'b1, 16'd1000, 1000);
        measure("R4 swallow 303 (A=15)", 1'b0, 1'b1, 16'd303, 303);
        measure("R5 swallow 100 floors to 256", 1'b0, 1'b1, 16'd100, 256);
    endtask

    task automatic test_fm();
        measure("R6 fm 300 swallow_en=1", 1'b1, 1'b1, 16'd300, 600);
        measure("R6 fm 300 swallow_en=0", 1'b1, 1'b0, 16'd300, 600);
        measure("R6 fm 20 floors to 256", 1'b1, 1'b0, 16'd20, 512);
    endtask

    task automatic test_change_mid_period();
        int n;
        measure("R7 baseline 100", 1'b0, 1'b0, 16'd100, 100);
        repeat (10) @(negedge clk);
        ratio = 16'd40;
        next_period(n);
        check("R7 period in progress keeps old ratio", n + 10, 100);
        next_period(n);
        check("R7 next period uses new ratio", n, 40);
    endtask

    task automatic test_gapped();
        am_alt = 1'b1;
        measure("R12 half-rate strobes double period", 1'b0, 1'b0, 16'd50, 100);
        am_alt = 1'b0;
    endtask

    task automatic test_full_swallow();
        measure("R4 swallow zero is 65536", 1'b0, 1'b1, 16'd0, 65536);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog R1..: run did not complete actual=timeout expected=done");
        finish_run();
    end

    initial begin
        test_reset();
        test_compare();
        test_direct();
        test_swallow();
        test_fm();
        test_change_mid_period();
        test_gapped();
        test_full_swallow();
        finish_run();
    end

endmodule